// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the software-facing front end of an eight-input interrupt controller. A host writes bytes to two addresses: address 0 (port A) and address 1 (port B). The block interprets each byte according to where it is in the setup sequence. A setup sequence always opens with a start word on port A. Then come one to three further words on port B. Flags in the start word decide how many follow. The block holds the configuration those words establish and presents it as plain output signals for the rest of the controller.

Once setup is complete, port B writes and reads go to the interrupt mask. Port A writes become commands. The block turns end-of-interrupt commands into one-cycle pulses for the priority logic. For a specific end-of-interrupt it also supplies the level. Cascade wiring, buffered operation and special nesting are only stored as fields. Nothing in this block acts on them.

Top module: `irqc_cmd_if`

## Requirements
- R1: After synchronous reset: `ready` is 0, `irq_mask` is 0, every configuration output is 0, and both command pulses are 0.
- R2: A port A write with bit 4 set is a start word. It captures trigger mode from bit 3, address interval from bit 2, single mode from bit 1 and the fourth-word flag from bit 0. It then waits for the second word on port B.
- R3: The second word, written to port B, loads `vec_base` from bits 7..3. Bits 2..0 have no effect.
- R4: The third word is expected only when single mode is 0. It is stored whole in `casc_cfg`. With single mode 1, `casc_cfg` reads 0 after the start word.
- R5: The fourth word is expected only when the fourth-word flag is 1. It loads `nested_full` from bit 4, `buffered` from bit 3, `buf_master` from bit 2, `auto_eoi` from bit 1 and `cpu_mode` from bit 0. When the flag is 0, these read 0.
- R6: `ready` rises in the cycle after the last expected word is written, and not before.
- R7: While ready, a port B write loads `irq_mask`. A `rd_en` at port B shows the mask on `rd_data` in the next cycle. A read at port A returns 0.
- R8: A start word at any time restarts the sequence. It drops `ready`, clears the mask, clears the cascade and fourth-word fields, and produces no pulse.
- R9: While ready, a port A byte whose bits 7..3 are 00100 gives a single-cycle `eoi_any` pulse in the cycle after the write.
- R10: While ready, a port A byte whose bits 7..3 are 01100 gives a single-cycle `eoi_spec` pulse. In that same cycle, `eoi_level` equals bits 2..0 of the byte.
- R11: Other port A bytes with bit 4 clear produce no pulse and leave the mask unchanged. This covers bytes with bit 7 (rotate) set, bit 5 clear, or bit 3 set. Port B writes and port A commands before the first completed sequence change nothing. So do port A commands during a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | 0 selects port A, 1 selects port B |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| ready | output | 1 | Setup sequence complete |
| vec_base | output | 5 | Vector base bits 7..3 |
| trig_level | output | 1 | Level-trigger mode flag |
| addr_interval | output | 1 | Address interval flag |
| single_mode | output | 1 | No cascade word expected |
| casc_cfg | output | 8 | Slave map or slave identity byte |
| nested_full | output | 1 | Special nesting flag (stored only) |
| buffered | output | 1 | Buffered operation flag (stored only) |
| buf_master | output | 1 | Master select in buffered operation (stored only) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enable |
| cpu_mode | output | 1 | Processor mode flag |
| irq_mask | output | 8 | Interrupt mask, 1 disables an input |
| eoi_any | output | 1 | Non-specific end-of-interrupt pulse |
| eoi_spec | output | 1 | Specific end-of-interrupt pulse |
| eoi_level | output | 3 | Level for the specific pulse |

## Verification
The bench runs every combination of the two sequence-length flags under sixteen start-word patterns and checks `ready` after each word. A sequencer that skips or demands an extra word would raise `ready` one write early or late, or would file a mask value into a configuration field. Every byte with bit 4 clear goes to port A while ready. Decoding that ignored the rotate bit or bits 4..3 would therefore produce pulses for rotate or register-select bytes, and a pulse that stretched would show up in the idle cycle after it. Restarts in mid-sequence and after completion check that a stale mask or fourth-word field cannot survive a new start word.

// File: rtl/irqc_cmd_pkg.sv
package irqc_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEQ_UNINIT = 3'd0,
    SEQ_W2     = 3'd1,
    SEQ_W3     = 3'd2,
    SEQ_W4     = 3'd3,
    SEQ_RUN    = 3'd4
  } seq_st_e;

  // start word: port A with bit 4 set
  function automatic logic is_start(input logic a, input logic [BYTE_W-1:0] d);
    return (a == 1'b0) && d[4];
  endfunction
endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              start_hit,
  output logic              run_wr_a,
  output logic              run_wr_b,
  output logic              ready,
  output logic [4:0]        vec_base,
  output logic              trig_level,
  output logic              addr_interval,
  output logic              single_mode,
  output logic              want_w4,
  output logic [BYTE_W-1:0] casc_cfg,
  output logic [4:0]        w4_bits
);
  seq_st_e st;
  logic    wr_b;

  assign start_hit = wr_en && is_start(addr, wdata);
  assign wr_b      = wr_en && addr;
  assign run_wr_a  = wr_en && !addr && !wdata[4] && (st == SEQ_RUN);
  assign run_wr_b  = wr_b && (st == SEQ_RUN);
  assign ready     = (st == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= SEQ_UNINIT;
      vec_base      <= '0;
      trig_level    <= 1'b0;
      addr_interval <= 1'b0;
      single_mode   <= 1'b0;
      want_w4       <= 1'b0;
      casc_cfg      <= '0;
      w4_bits       <= '0;
    end else if (start_hit) begin
      st            <= SEQ_W2;
      trig_level    <= wdata[3];
      addr_interval <= wdata[2];
      single_mode   <= wdata[1];
      want_w4       <= wdata[0];
      casc_cfg      <= '0;
      w4_bits       <= '0;
    end else if (wr_b) begin
      unique case (st)
        SEQ_W2: begin
          vec_base <= wdata[7:3];
          if (!single_mode)  st <= SEQ_W3;
          else if (want_w4)  st <= SEQ_W4;
          else               st <= SEQ_RUN;
        end
        SEQ_W3: begin
          casc_cfg <= wdata;
          st       <= want_w4 ? SEQ_W4 : SEQ_RUN;
        end
        SEQ_W4: begin
          w4_bits <= wdata[4:0];
          st      <= SEQ_RUN;
        end
        default: st <= st;
      endcase
    end
  end

  // R6
  w2_last_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_W2 && wr_b && !start_hit && single_mode && !want_w4) |=> ready);
  // R4
  w3_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_W2 && wr_b && !start_hit && !single_mode) |=> !ready);
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_hit |=> (!ready && casc_cfg == '0 && w4_bits == '0));
  // R3
  vbase_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_W2 && wr_b && !start_hit) |=> vec_base == $past(wdata[7:3]));
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
  import irqc_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               load,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [NUM_IRQ-1:0] mask,
  output logic [BYTE_W-1:0]  rd_data
);
  always_ff @(posedge clk) begin
    if (rst || clear) mask <= '0;
    else if (load)    mask <= wdata[NUM_IRQ-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= addr ? BYTE_W'(mask) : '0;
  end

  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> mask == $past(wdata[NUM_IRQ-1:0]));
  // R8
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> mask == '0);
  // R7
  mask_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr) |=> rd_data == BYTE_W'($past(mask)));
endmodule

// File: rtl/irqc_ocw_dec.sv
module irqc_ocw_dec
  import irqc_cmd_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              eoi_any,
  output logic              eoi_spec,
  output logic [LVL_W-1:0]  eoi_level
);
  logic is_ocw2, ns_hit, sp_hit;

  assign is_ocw2 = cmd_wr && (wdata[4:3] == 2'b00) && !wdata[7] && wdata[5];
  assign ns_hit  = is_ocw2 && !wdata[6];
  assign sp_hit  = is_ocw2 &&  wdata[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_any   <= 1'b0;
      eoi_spec  <= 1'b0;
      eoi_level <= '0;
    end else begin
      eoi_any  <= ns_hit;
      eoi_spec <= sp_hit;
      if (sp_hit) eoi_level <= wdata[LVL_W-1:0];
    end
  end

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> (!eoi_any && !eoi_spec));
  // R10
  level_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_spec |-> eoi_level == $past(wdata[LVL_W-1:0]));
  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_any |-> !eoi_spec);
endmodule

// File: rtl/irqc_cmd_if.sv
module irqc_cmd_if
  import irqc_cmd_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int LVL_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               addr,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               ready,
  output logic [4:0]         vec_base,
  output logic               trig_level,
  output logic               addr_interval,
  output logic               single_mode,
  output logic [BYTE_W-1:0]  casc_cfg,
  output logic               nested_full,
  output logic               buffered,
  output logic               buf_master,
  output logic               auto_eoi,
  output logic               cpu_mode,
  output logic [NUM_IRQ-1:0] irq_mask,
  output logic               eoi_any,
  output logic               eoi_spec,
  output logic [LVL_W-1:0]   eoi_level
);
  logic       start_hit, run_wr_a, run_wr_b, want_w4;
  logic [4:0] w4_bits;

  irqc_init_seq u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .start_hit(start_hit), .run_wr_a(run_wr_a), .run_wr_b(run_wr_b),
    .ready(ready), .vec_base(vec_base), .trig_level(trig_level),
    .addr_interval(addr_interval), .single_mode(single_mode),
    .want_w4(want_w4), .casc_cfg(casc_cfg), .w4_bits(w4_bits)
  );

  assign nested_full = w4_bits[4];
  assign buffered    = w4_bits[3];
  assign buf_master  = w4_bits[2];
  assign auto_eoi    = w4_bits[1];
  assign cpu_mode    = w4_bits[0];

  irqc_mask_reg #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .clk(clk), .rst(rst), .clear(start_hit), .load(run_wr_b),
    .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .mask(irq_mask), .rd_data(rd_data)
  );

  irqc_ocw_dec #(.LVL_W(LVL_W)) u_ocw (
    .clk(clk), .rst(rst), .cmd_wr(run_wr_a), .wdata(wdata),
    .eoi_any(eoi_any), .eoi_spec(eoi_spec), .eoi_level(eoi_level)
  );

  // R11
  pulse_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_any || eoi_spec) |-> $past(ready));
endmodule

// File: tb/irqc_cmd_if_test.sv
module irqc_cmd_if_test;
  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en, addr;
  logic [7:0] wdata, rd_data, casc_cfg, irq_mask;
  logic [4:0] vec_base;
  logic [2:0] eoi_level;
  logic       ready, trig_level, addr_interval, single_mode;
  logic       nested_full, buffered, buf_master, auto_eoi, cpu_mode;
  logic       eoi_any, eoi_spec;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irqc_cmd_if uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .ready(ready), .vec_base(vec_base),
    .trig_level(trig_level), .addr_interval(addr_interval),
    .single_mode(single_mode), .casc_cfg(casc_cfg),
    .nested_full(nested_full), .buffered(buffered), .buf_master(buf_master),
    .auto_eoi(auto_eoi), .cpu_mode(cpu_mode), .irq_mask(irq_mask),
    .eoi_any(eoi_any), .eoi_spec(eoi_spec), .eoi_level(eoi_level)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle_quiet(input string req);
    @(negedge clk);
    check(req, {eoi_any, eoi_spec}, 0);
  endtask

  task automatic icw4_zero(input string req);
    check(req, {nested_full, buffered, buf_master, auto_eoi, cpu_mode}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", ready, 0);
    check("R1 mask", irq_mask, 0);
    check("R1 cfg", {vec_base, trig_level, addr_interval, single_mode, casc_cfg}, 0);
    icw4_zero("R1 w4");
    check("R1 pulses", {eoi_any, eoi_spec}, 0);

    // R11: before any sequence, port B and port A commands do nothing
    wr(1'b1, 8'hA5);
    check("R11 pre mask", irq_mask, 0);
    check("R11 pre ready", ready, 0);
    wr(1'b0, 8'h20);
    check("R11 pre pulse", {eoi_any, eoi_spec}, 0);

    // R2..R6 sweep over start-word flags and data patterns
    for (int v = 0; v < 64; v++) begin
      logic [7:0] w1, w2, w3, w4;
      logic       sg, f4;
      w1 = 8'h10 | 8'(v & 15);
      sg = w1[1]; f4 = w1[0];
      w2 = 8'((v * 37 + 5) & 255);
      w3 = 8'((v * 53 + 9) & 255);
      w4 = 8'((v * 7 + 3) & 31);
      wr(1'b0, w1);
      check("R2 ready low", ready, 0);
      check("R2 flags", {trig_level, addr_interval, single_mode}, {29'd0, w1[3:1]});
      check("R8 casc cleared", casc_cfg, 0);
      icw4_zero("R8 w4 cleared");
      if (v == 5) begin
        // R11: command on port A during a sequence is ignored
        wr(1'b0, 8'h20);
        check("R11 mid pulse", {eoi_any, eoi_spec}, 0);
      end
      wr(1'b1, w2);
      check("R3 vec_base", vec_base, int'(w2[7:3]));
      check("R6 after w2", ready, (sg && !f4) ? 1 : 0);
      if (!sg) begin
        wr(1'b1, w3);
        check("R4 casc", casc_cfg, int'(w3));
        check("R6 after w3", ready, f4 ? 0 : 1);
      end else begin
        check("R4 casc zero", casc_cfg, 0);
      end
      if (f4) begin
        wr(1'b1, w4);
        check("R5 w4 fields",
              {nested_full, buffered, buf_master, auto_eoi, cpu_mode}, int'(w4[4:0]));
        check("R6 after w4", ready, 1);
      end else begin
        icw4_zero("R5 no w4");
      end
      check("R3 vec hold", vec_base, int'(w2[7:3]));
      check("R8 mask clear", irq_mask, 0);
    end

    // R7 mask sweep with read back
    for (int m = 0; m < 256; m++) begin
      wr(1'b1, 8'(m));
      check("R7 mask", irq_mask, m);
      rd(1'b1);
      check("R7 rd", rd_data, m);
    end
    rd(1'b0);
    check("R7 rd port A", rd_data, 0);

    // R9 R10 R11 port A command sweep while ready, mask is 8'hFF
    for (int b = 0; b < 256; b++) begin
      logic [7:0] d;
      logic       ens, esp;
      d = 8'(b);
      if (d[4]) continue;
      ens = (d[7:3] == 5'b00100);
      esp = (d[7:3] == 5'b01100);
      wr(1'b0, d);
      check(esp ? "R10 pulse" : (ens ? "R9 pulse" : "R11 pulse"),
            {eoi_any, eoi_spec}, {30'd0, ens, esp});
      if (esp) check("R10 level", eoi_level, int'(d[2:0]));
      check("R11 mask kept", irq_mask, 8'hFF);
      check("R6 still ready", ready, 1);
      idle_quiet("R9 one cycle");
    end

    // R8 restart in mid sequence, then from ready
    wr(1'b0, 8'h11);
    check("R8 ready drop", ready, 0);
    check("R8 mask zero", irq_mask, 0);
    wr(1'b1, 8'h48);
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h88);
    check("R8 restart done", ready, 1);
    check("R8 vec", vec_base, 5'h11);
    wr(1'b1, 8'h3C);
    wr(1'b0, 8'h1B);
    check("R8 restart pulse", {eoi_any, eoi_spec}, 0);
    check("R8 restart mask", irq_mask, 0);
    check("R8 restart ready", ready, 0);
    finish_run();
  end
endmodule